// File: doc/BRIEF.md
# Spread-Spectrum Divider Word Sweeper

This block produces a time-varying feedback-divider word for a fractional-N synthesizer. Changing that word moves the synthesized clock frequency across a programmed band, which spreads the clock energy and lowers peak emissions. The word is unsigned fixed point with 8 integer bits and 16 fractional bits. Each pulse of a reference-rate `tick` produces one new word, which is presented with a one-cycle `div_valid` strobe.

Three sweep shapes are available. The first is a linear triangle. The second is a triangle whose slope shrinks close to both turnarounds. The third picks offsets from a fixed 16-level table in a pseudo-random order. The band can sit symmetrically around the nominal word (center spread), or entirely below it (down spread). The spread depth is given as a count of fractional LSBs. The modulation period is given as a number of ticks. A configuration written mid-period is held off until the next period begins. Dropping the enable returns the output to the nominal word at once.

Top module: `ssc_profile_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `div_word` is 0 and `div_valid` is 0.
- R2: `div_valid` is high in exactly the cycle after each cycle in which `tick` is high. `div_word` changes only in those cycles.
- R3: A tick with `spread_en` low makes `div_word` equal the live `nominal_word` and resets the period position. The next enabled tick is then the first tick of a new period.
- R4: With `profile_sel` 0 (also 3), the offset is 0 at the first tick of a period. Let step = floor(S / (P/2)), where S is the span and P is the period. The offset rises by step per tick through the first half of the period and falls by step per tick through the second half.
- R5: With `down_mode` 0 (center), the base is nominal − floor(D/2) and the span is S = 2·floor(D/2). The word never exceeds nominal + floor(D/2).
- R6: With `down_mode` 1 (down), the base is nominal − D and S = D. The word never exceeds nominal, and it reaches nominal when S is a multiple of P/2.
- R7: With `profile_sel` 1 (tapered), the period is split into 16 sub-intervals of P/16 ticks each. During sub-interval j, the per-tick change is floor(step·w/4), where w is taken from position j mod 8 through the table 1,3,5,7,7,5,3,1. The offset rises during sub-intervals 0–7 and falls during 8–15.
- R8: With `profile_sel` 2 (sequence), the offset is floor(S·i/16). Here i is bits [3:0] of a 16-bit shift register that resets to 0xACE1. The register advances on the last tick of each sub-interval as next = {s[0]^s[2]^s[3]^s[5], s[15:1]}. It advances only while enabled in this profile.
- R9: Nominal word, depth, period, mode and profile are captured at the first tick of a period. Changes made at any other time have no effect until the next period starts.
- R10: The triangle accumulator saturates at 0 and at S. Every enabled word therefore lies between base and base + S of the captured configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference-rate step pulse, one cycle wide |
| spread_en | input | 1 | 1: modulate, 0: output nominal word |
| down_mode | input | 1 | 0: center spread, 1: down spread |
| profile_sel | input | 2 | 0 triangle, 1 tapered triangle, 2 sequence, 3 triangle |
| nominal_word | input | 24 | Nominal divider word, 8.16 fixed point |
| spread_depth | input | 16 | Spread depth in fractional LSBs |
| period_ticks | input | 16 | Modulation period in ticks |
| div_word | output | 24 | Instantaneous divider word |
| div_valid | output | 1 | High for one cycle when `div_word` is updated |

## Verification
The bound assertions assume three things about the inputs. First, `nominal_word` is at least `spread_depth`, so the base cannot wrap below zero. Second, `period_ticks` is a non-zero multiple of 16, so the sub-intervals and the half-period split evenly. Third, `tick` is a single-cycle pulse. The stimulus uses a nominal word near 100.0 and depths of a few thousand LSBs at most, so the first assumption always holds. It draws periods only from 16, 32 and 64, which satisfies the second. It raises `tick` for exactly one cycle, with idle cycles between pulses, which satisfies the third. Depths include odd values and values that divide the half-period exactly, so both the rounded and the exact-peak cases are exercised within those limits.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [1:0] {
    PROF_TRI   = 2'd0,
    PROF_TAPER = 2'd1,
    PROF_SEQ   = 2'd2,
    PROF_ALT   = 2'd3
  } prof_e;

  localparam int SUB_LOG2  = 4;
  localparam int SUBS      = 1 << SUB_LOG2;
  localparam int LFSR_W    = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // slope weight in quarters of the nominal step, by position within a half
  function automatic logic [2:0] taper_weight(input logic [SUB_LOG2-2:0] pos);
    logic [2:0] w;
    case (pos)
      3'd0, 3'd7: w = 3'd1;
      3'd1, 3'd6: w = 3'd3;
      3'd2, 3'd5: w = 3'd5;
      default:    w = 3'd7;
    endcase
    return w;
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[5], s[LFSR_W-1:1]};
  endfunction

endpackage

// File: rtl/ssc_cfg_calc.sv
module ssc_cfg_calc #(
  parameter int WORD_W  = 24,
  parameter int DEPTH_W = 16,
  parameter int PER_W   = 16
) (
  input  logic [WORD_W-1:0]  nom,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [PER_W-1:0]   period,
  input  logic               down,
  output logic [WORD_W-1:0]  base,
  output logic [DEPTH_W-1:0] span,
  output logic [DEPTH_W-1:0] step
);
  localparam int PAD_W = WORD_W - DEPTH_W;

  logic [DEPTH_W-1:0] half_depth;
  logic [DEPTH_W-1:0] below;
  logic [PER_W-1:0]   half_per;

  function automatic logic [DEPTH_W-1:0] udiv(input logic [DEPTH_W-1:0] n,
                                               input logic [PER_W-1:0] d);
    logic [PER_W:0]     r;
    logic [DEPTH_W-1:0] q;
    r = '0;
    q = '0;
    for (int i = DEPTH_W - 1; i >= 0; i--) begin
      r = {r[PER_W-1:0], n[i]};
      if (r >= {1'b0, d}) begin
        r    = r - {1'b0, d};
        q[i] = 1'b1;
      end
    end
    return q;
  endfunction

  always_comb begin
    half_depth = depth >> 1;
    below      = down ? depth : half_depth;
    span       = down ? depth : DEPTH_W'(half_depth << 1);
    base       = nom - {{PAD_W{1'b0}}, below};
    half_per   = period >> 1;
    step       = (half_per == '0) ? '0 : udiv(span, half_per);
  end

endmodule

// File: rtl/ssc_period_ctrl.sv
module ssc_period_ctrl
  import ssc_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int DEPTH_W = 16,
  parameter int PER_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                en,
  input  logic [WORD_W-1:0]   in_nom,
  input  logic [DEPTH_W-1:0]  in_depth,
  input  logic [PER_W-1:0]    in_per,
  input  logic                in_down,
  input  logic [1:0]          in_prof,
  output logic [WORD_W-1:0]   use_nom,
  output logic [DEPTH_W-1:0]  use_depth,
  output logic [PER_W-1:0]    use_per,
  output logic                use_down,
  output prof_e               use_prof,
  output logic                start,
  output logic [SUB_LOG2-1:0] sub_idx,
  output logic                last_sub
);
  logic [WORD_W-1:0]  nom_q;
  logic [DEPTH_W-1:0] depth_q;
  logic [PER_W-1:0]   per_q;
  logic               down_q;
  logic [1:0]         prof_q;
  logic [PER_W-1:0]   cnt_q;
  logic [SUB_LOG2-1:0] sub_q;
  logic [PER_W-1:0]   seg_raw;
  logic [PER_W-1:0]   seg_len;
  logic [1:0]         prof_sel;

  always_comb begin
    start     = (cnt_q == '0) && (sub_q == '0);
    use_nom   = start ? in_nom   : nom_q;
    use_depth = start ? in_depth : depth_q;
    use_per   = start ? in_per   : per_q;
    use_down  = start ? in_down  : down_q;
    prof_sel  = start ? in_prof  : prof_q;
    use_prof  = (prof_sel == PROF_ALT) ? PROF_TRI : prof_e'(prof_sel);
    seg_raw   = use_per >> SUB_LOG2;
    seg_len   = (seg_raw == '0) ? PER_W'(1) : seg_raw;
    last_sub  = (cnt_q == seg_len - PER_W'(1));
    sub_idx   = sub_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nom_q   <= '0;
      depth_q <= '0;
      per_q   <= '0;
      down_q  <= 1'b0;
      prof_q  <= '0;
      cnt_q   <= '0;
      sub_q   <= '0;
    end else if (tick) begin
      if (!en) begin
        cnt_q <= '0;
        sub_q <= '0;
      end else begin
        if (start) begin
          nom_q   <= in_nom;
          depth_q <= in_depth;
          per_q   <= in_per;
          down_q  <= in_down;
          prof_q  <= in_prof;
        end
        if (last_sub) begin
          cnt_q <= '0;
          sub_q <= sub_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R9: within a period the position counter stays inside the captured sub-interval length
  p_subcount_bound_r9: assert property (@(posedge clk) disable iff (rst)
    !start |-> (cnt_q < seg_len));

  // R9: captured configuration is untouched except on the first tick of a period
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(tick && en && start) |=> ($stable(nom_q) && $stable(depth_q) && $stable(per_q)
                                && $stable(down_q) && $stable(prof_q)));

endmodule

// File: rtl/ssc_seq_source.sv
module ssc_seq_source
  import ssc_pkg::*;
#(
  parameter int DEPTH_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               advance,
  input  logic [DEPTH_W-1:0] span,
  output logic [DEPTH_W-1:0] seq_off
);
  localparam int PROD_W = DEPTH_W + SUB_LOG2;

  logic [LFSR_W-1:0] lfsr_q;
  logic [PROD_W-1:0] prod;

  always_ff @(posedge clk) begin
    if (rst) lfsr_q <= LFSR_SEED;
    else if (advance) lfsr_q <= lfsr_step(lfsr_q);
  end

  // uniform 16-level table over the span, computed rather than stored
  always_comb begin
    prod    = PROD_W'(span) * PROD_W'(lfsr_q[SUB_LOG2-1:0]);
    seq_off = DEPTH_W'(prod >> SUB_LOG2);
  end

  // R8: the sequence register never locks up in the all-zero state
  p_lfsr_live_r8: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);

  // R8: every advance moves the sequence to a new state
  p_lfsr_moves_r8: assert property (@(posedge clk) disable iff (rst)
    advance |=> (lfsr_q != $past(lfsr_q)));

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int INT_W   = 8,
  parameter int FRAC_W  = 16,
  parameter int DEPTH_W = 16,
  parameter int PER_W   = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick,
  input  logic                      spread_en,
  input  logic                      down_mode,
  input  logic [1:0]                profile_sel,
  input  logic [INT_W+FRAC_W-1:0]   nominal_word,
  input  logic [DEPTH_W-1:0]        spread_depth,
  input  logic [PER_W-1:0]          period_ticks,
  output logic [INT_W+FRAC_W-1:0]   div_word,
  output logic                      div_valid
);
  localparam int WORD_W = INT_W + FRAC_W;
  localparam int PAD_W  = WORD_W - DEPTH_W;
  localparam int TPR_W  = DEPTH_W + 3;

  logic [WORD_W-1:0]   use_nom;
  logic [DEPTH_W-1:0]  use_depth;
  logic [PER_W-1:0]    use_per;
  logic                use_down;
  prof_e               use_prof;
  logic                start;
  logic [SUB_LOG2-1:0] sub_idx;
  logic                last_sub;
  logic [WORD_W-1:0]   base;
  logic [DEPTH_W-1:0]  span;
  logic [DEPTH_W-1:0]  step;
  logic [DEPTH_W-1:0]  seq_off;
  logic                seq_adv;

  ssc_period_ctrl #(.WORD_W(WORD_W), .DEPTH_W(DEPTH_W), .PER_W(PER_W)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .en(spread_en),
    .in_nom(nominal_word), .in_depth(spread_depth), .in_per(period_ticks),
    .in_down(down_mode), .in_prof(profile_sel),
    .use_nom(use_nom), .use_depth(use_depth), .use_per(use_per),
    .use_down(use_down), .use_prof(use_prof),
    .start(start), .sub_idx(sub_idx), .last_sub(last_sub)
  );

  ssc_cfg_calc #(.WORD_W(WORD_W), .DEPTH_W(DEPTH_W), .PER_W(PER_W)) u_cfg (
    .nom(use_nom), .depth(use_depth), .period(use_per), .down(use_down),
    .base(base), .span(span), .step(step)
  );

  assign seq_adv = tick && spread_en && (use_prof == PROF_SEQ) && last_sub;

  ssc_seq_source #(.DEPTH_W(DEPTH_W)) u_seq (
    .clk(clk), .rst(rst), .advance(seq_adv), .span(span), .seq_off(seq_off)
  );

  // triangle / tapered accumulator
  logic [DEPTH_W-1:0] acc_q;
  logic [DEPTH_W-1:0] acc_cur;
  logic [DEPTH_W-1:0] acc_next;
  logic [DEPTH_W-1:0] delta;
  logic [TPR_W-1:0]   taper_prod;
  logic [DEPTH_W:0]   acc_sum;
  logic               rising;
  logic [DEPTH_W-1:0] offset;
  logic [WORD_W-1:0]  word_next;

  always_comb begin
    acc_cur    = start ? '0 : acc_q;
    rising     = !sub_idx[SUB_LOG2-1];
    taper_prod = TPR_W'(step) * TPR_W'(taper_weight(sub_idx[SUB_LOG2-2:0]));
    delta      = (use_prof == PROF_TAPER) ? DEPTH_W'(taper_prod >> 2) : step;
    acc_sum    = {1'b0, acc_cur} + {1'b0, delta};
    if (rising)
      acc_next = (acc_sum > {1'b0, span}) ? span : acc_sum[DEPTH_W-1:0];
    else
      acc_next = (acc_cur > delta) ? (acc_cur - delta) : '0;
    offset     = (use_prof == PROF_SEQ) ? seq_off : acc_cur;
    word_next  = base + {{PAD_W{1'b0}}, offset};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      div_word  <= '0;
      div_valid <= 1'b0;
    end else begin
      div_valid <= tick;
      if (tick) begin
        if (spread_en) begin
          acc_q    <= acc_next;
          div_word <= word_next;
        end else begin
          acc_q    <= '0;
          div_word <= nominal_word;
        end
      end
    end
  end

  // band edges from the captured configuration, kept apart from the datapath sum
  logic [WORD_W-1:0] band_top;
  logic [WORD_W-1:0] band_bot;
  always_comb begin
    band_top = use_down ? use_nom : use_nom + {{PAD_W{1'b0}}, use_depth >> 1};
    band_bot = use_nom - {{PAD_W{1'b0}}, (use_down ? use_depth : (use_depth >> 1))};
  end

  // R2: one strobe per tick, one cycle later
  p_valid_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (div_valid == $past(tick)));

  // R3: a disabled tick yields the live nominal word
  p_idle_nominal_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tick && !spread_en)) |-> (div_word == $past(nominal_word)));

  // R6: never above the band top (nominal in down spread, nominal + D/2 in center)
  p_ceiling_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tick && spread_en)) |-> (div_word <= $past(band_top)));

  // R5: never below the band bottom
  p_floor_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tick && spread_en)) |-> (div_word >= $past(band_bot)));

  // R10: the accumulator stays inside the captured span
  p_acc_bound_r10: assert property (@(posedge clk) disable iff (rst)
    !start |-> (acc_q <= span));

  // R2: the word only moves on a strobe
  p_word_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !div_valid |-> $stable(div_word));

endmodule

// File: tb/ssc_profile_gen_tb.sv
`timescale 1ns/1ps
module ssc_profile_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        spread_en = 1'b0;
  logic        down_mode = 1'b0;
  logic [1:0]  profile_sel = 2'd0;
  logic [23:0] nominal_word = 24'h640000;
  logic [15:0] spread_depth = 16'd0;
  logic [15:0] period_ticks = 16'd16;
  logic [23:0] div_word;
  logic        div_valid;

  always #2.5 clk = ~clk;

  ssc_profile_gen u_dut (
    .clk(clk), .rst(rst), .tick(tick), .spread_en(spread_en),
    .down_mode(down_mode), .profile_sel(profile_sel),
    .nominal_word(nominal_word), .spread_depth(spread_depth),
    .period_ticks(period_ticks), .div_word(div_word), .div_valid(div_valid)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model state
  int m_j = 0, m_c = 0, m_p = 0;
  int l_nom = 0, l_d = 0, l_per = 16, l_down = 0, l_prof = 0;
  logic [15:0] m_lfsr = 16'hACE1;
  int last_top = 0, last_bot = 0;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_le(string req, int a, int b);
    n_checks++;
    if (a > b) begin
      n_fail++;
      $display("FAIL %s: got %0d expected at most %0d", req, a, b);
    end
  endtask

  function automatic int wt(int pos);
    case (pos)
      0, 7: return 1;
      1, 6: return 3;
      2, 5: return 5;
      default: return 7;
    endcase
  endfunction

  task automatic model_tick(output int e);
    int s, base, step, seg, pcur, off, delta, prof;
    if (!spread_en) begin
      e = nominal_word; m_j = 0; m_c = 0; m_p = 0;
      return;
    end
    if (m_j == 0 && m_c == 0) begin
      l_nom = nominal_word; l_d = spread_depth; l_per = period_ticks;
      l_down = down_mode; l_prof = profile_sel;
      pcur = 0;
    end else pcur = m_p;
    prof = (l_prof == 3) ? 0 : l_prof;
    s    = l_down ? l_d : 2 * (l_d / 2);
    base = l_down ? l_nom - l_d : l_nom - l_d / 2;
    step = s / (l_per / 2);
    seg  = l_per / 16;
    last_top = l_down ? l_nom : l_nom + l_d / 2;
    last_bot = base;
    off = (prof == 2) ? (s * int'(m_lfsr[3:0])) / 16 : pcur;
    e = base + off;
    delta = (prof == 1) ? (step * wt(m_j % 8)) / 4 : step;
    if (m_j < 8) m_p = (pcur + delta > s) ? s : pcur + delta;
    else         m_p = (pcur > delta) ? pcur - delta : 0;
    if (m_c == seg - 1) begin
      if (prof == 2) m_lfsr = {m_lfsr[0] ^ m_lfsr[2] ^ m_lfsr[3] ^ m_lfsr[5], m_lfsr[15:1]};
      m_c = 0; m_j = (m_j + 1) % 16;
    end else m_c++;
  endtask

  // one tick; returns observed word, checks strobe and model
  task automatic do_tick(string req, output int got);
    int e;
    @(negedge clk);
    tick = 1'b1;
    model_tick(e);
    @(negedge clk);
    tick = 1'b0;
    got = div_word;
    check("R2 strobe", int'(div_valid), 1);
    check(req, got, e);
    if (spread_en) begin
      check_le("R6 ceiling", got, last_top);
      check_le("R10 floor", last_bot, got);
    end
    @(negedge clk);
    check("R2 strobe low", int'(div_valid), 0);
  endtask

  task automatic resync();
    int g;
    spread_en = 1'b0;
    do_tick("R3 disabled", g);
    spread_en = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int g;
    string tag;
    repeat (4) @(negedge clk);
    check("R1 word in reset", int'(div_word), 0);
    check("R1 valid in reset", int'(div_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 word after reset", int'(div_word), 0);
    check("R1 valid after reset", int'(div_valid), 0);

    // R3: disabled output is the live nominal
    nominal_word = 24'h640123;
    do_tick("R3 nominal", g);
    check("R3 exact nominal", g, 24'h640123);
    nominal_word = 24'h640000;

    // R8: first sequence offsets from the reset seed 0xACE1
    spread_en = 1'b1; down_mode = 1'b1; profile_sel = 2'd2;
    spread_depth = 16'd1600; period_ticks = 16'd16;
    do_tick("R8 seq", g);
    check("R8 seed index 1", g, 24'h640000 - 1600 + 100);
    do_tick("R8 seq", g);
    check("R8 next index 0", g, 24'h640000 - 1600);

    // R7: first tapered step uses weight 1
    resync();
    profile_sel = 2'd1; period_ticks = 16'd64;
    do_tick("R7 taper", g);
    check("R7 period start at base", g, 24'h640000 - 1600);
    do_tick("R7 taper", g);
    check("R7 slow first slope", g, 24'h640000 - 1600 + 12);

    // R6 / R5: exact peak reached at mid-period
    for (int md = 0; md < 2; md++) begin
      resync();
      profile_sel = 2'd0; down_mode = md[0]; period_ticks = 16'd32;
      for (int k = 0; k < 32; k++) begin
        do_tick(md ? "R6 triangle" : "R5 triangle", g);
        if (k == 16) check(md ? "R6 peak at nominal" : "R5 peak at nominal+D/2",
                           g, md ? 24'h640000 : 24'h640000 + 800);
        if (k == 1) check("R4 one step", g, 24'h640000 - (md ? 1600 : 800) + 100);
      end
    end

    // R9: mid-period reconfiguration deferred; R3: disable restarts the period
    resync();
    profile_sel = 2'd0; down_mode = 1'b1; spread_depth = 16'd1000; period_ticks = 16'd32;
    for (int k = 0; k < 5; k++) do_tick("R4 triangle", g);
    spread_depth = 16'd3000; down_mode = 1'b0; profile_sel = 2'd2;
    do_tick("R9 deferred", g);
    check("R9 old config kept", g, 24'h640000 - 1000 + 5 * 62);
    for (int k = 6; k < 32; k++) do_tick("R9 deferred", g);
    do_tick("R9 new period", g);
    check("R9 new config at start", g, 24'h640000 - 1500 + (3000 * int'(m_lfsr_prev_idx())) / 16);
    spread_en = 1'b0;
    do_tick("R3 mid-period", g);
    check("R3 nominal mid-period", g, 24'h640000);
    spread_en = 1'b1; profile_sel = 2'd0; down_mode = 1'b1; spread_depth = 16'd1000;
    do_tick("R3 restart", g);
    check("R3 restart at base", g, 24'h640000 - 1000);

    // near-exhaustive sweep
    for (int pi = 0; pi < 3; pi++)
      for (int md = 0; md < 2; md++)
        for (int pr = 0; pr < 4; pr++)
          for (int di = 0; di < 3; di++) begin
            resync();
            period_ticks = 16'(16 << pi);
            down_mode    = md[0];
            profile_sel  = 2'(pr);
            spread_depth = (di == 0) ? 16'd1000 : (di == 1) ? 16'd1001 : 16'd1600;
            tag = (pr == 1) ? "R7 taper" : (pr == 2) ? "R8 seq" : "R4 triangle";
            for (int k = 0; k < 2 * (16 << pi); k++) do_tick(tag, g);
          end

    done = 1;
    summary();
    $finish;
  end

  // index used by the sequence on the tick just modelled (state before advance)
  logic [15:0] seq_hist;
  function automatic logic [3:0] m_lfsr_prev_idx();
    return seq_hist[3:0];
  endfunction
  always @(posedge clk) if (tick) seq_hist <= m_lfsr;

endmodule